// File: doc/BRIEF.md
# Legacy Peripheral Resource Decoder

This block turns a handful of configuration bytes into the I/O resources of four classic peripherals: a floppy controller, two serial ports and a parallel port. From the configuration bytes it derives each device's base address and whether its address decode is on. It keeps the interrupt line and DMA channel numbers for these devices in small registers, loaded by writes from the bridge side. All other paths are combinational.

Each I/O cycle presents a 16-bit port address. The block compares this address against every enabled window. It raises a one-hot chip select for the device that owns the address. When windows overlap, a fixed priority picks the owner.

Routing writes arrive on a valid/ready channel. `route_ready` is held high, so there is never back-pressure. A write completes on every clock edge where `route_valid` is high.

Top module: `lpr_decoder`

## Requirements
- R1: The floppy base equals `cfg_fdc` with bits [1:0] cleared, shifted left by 2. `fdc_en` follows `cfg_ctl[4]`.
- R2: Each serial base equals its config byte (`cfg_ser_a` or `cfg_ser_b`) with bit 0 cleared, shifted left by 2. `sera_en` follows `cfg_ctl[2]` and `serb_en` follows `cfg_ctl[3]`.
- R3: The parallel window is 8 bytes wide (`lpt_wide` = 1) when `cfg_ctl[1:0]` is 2, and 4 bytes wide otherwise. Its base is `cfg_lpt` shifted left by 2, with bit 2 cleared when the window is 8 bytes.
- R4: `lpt_en` is 1 only when all of these hold: `cfg_ctl[1:0]` is not 3, the base is at least 0x100, and the base is at most 0x3FC (4-byte window) or 0x3F8 (8-byte window).
- R5: A routing write at offset 0x50 loads the floppy DMA channel from data bits [1:0] and the parallel DMA channel from data bits [3:2].
- R6: A routing write at offset 0x51 loads the floppy IRQ from data bits [3:0] and the parallel IRQ from data bits [7:4].
- R7: A routing write at offset 0x52 loads the serial A IRQ from data bits [3:0] and the serial B IRQ from data bits [7:4].
- R8: After reset, the floppy DMA channel is 2, the parallel DMA channel is 3 and all IRQ numbers are 0.
- R9: A routing write at any offset other than 0x50, 0x51 or 0x52 leaves every IRQ and DMA output unchanged.
- R10: `sel` is one-hot or zero. Bit 0 is the floppy, bit 1 serial A, bit 2 serial B and bit 3 the parallel port. A device's bit is set when the device is enabled, the address lies inside its window and no lower-numbered bit hits. The floppy and serial windows are 8 bytes long.
- R11: The IRQ and DMA outputs of a device whose decode is disabled read 0.
- R12: `route_ready` is always 1, so each cycle with `route_valid` high performs one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctl | input | 8 | Control byte: [1:0] parallel mode, [2] serial A on, [3] serial B on, [4] floppy on |
| cfg_fdc | input | 8 | Floppy base byte |
| cfg_lpt | input | 8 | Parallel base byte |
| cfg_ser_a | input | 8 | Serial A base byte |
| cfg_ser_b | input | 8 | Serial B base byte |
| route_valid | input | 1 | Routing write request |
| route_ready | output | 1 | Routing write accept, always 1 |
| route_off | input | 8 | Routing write offset |
| route_data | input | 8 | Routing write data |
| io_addr | input | ADDR_W | I/O port address to decode |
| fdc_base | output | ADDR_W | Floppy base address |
| fdc_en | output | 1 | Floppy decode enabled |
| fdc_irq | output | 4 | Floppy IRQ number |
| fdc_dma | output | 2 | Floppy DMA channel |
| sera_base | output | ADDR_W | Serial A base address |
| sera_en | output | 1 | Serial A decode enabled |
| sera_irq | output | 4 | Serial A IRQ number |
| serb_base | output | ADDR_W | Serial B base address |
| serb_en | output | 1 | Serial B decode enabled |
| serb_irq | output | 4 | Serial B IRQ number |
| lpt_base | output | ADDR_W | Parallel base address |
| lpt_en | output | 1 | Parallel decode enabled |
| lpt_wide | output | 1 | Parallel window is 8 bytes |
| lpt_irq | output | 4 | Parallel IRQ number |
| lpt_dma | output | 2 | Parallel DMA channel |
| sel | output | 4 | One-hot chip selects |

## Verification
The routing properties compare a register with the data of the previous cycle. They therefore assume that `route_valid` stays low while reset is asserted, and the stimulus raises it only between falling edges after reset is released. The decode properties assume that the configuration bytes and `io_addr` are settled at each rising edge. The stimulus changes them only a fraction of a cycle after a falling edge, or between edges with no routing write pending. The sweeps cover every value of each config byte and every parallel mode. They also place overlapping windows so that the priority order gets exercised.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  localparam int unsigned CFG_W   = 8;
  localparam int unsigned IRQ_W   = 4;
  localparam int unsigned DMA_W   = 2;
  localparam int unsigned NUM_DEV = 4;
  localparam int unsigned NUM_SER = 2;
  localparam int unsigned SEL_W   = NUM_DEV;

  // chip-select index, also the priority order (lower wins)
  typedef enum logic [1:0] {
    DEV_FDC  = 2'd0,
    DEV_SERA = 2'd1,
    DEV_SERB = 2'd2,
    DEV_LPT  = 2'd3
  } dev_idx_e;

  // control byte fields
  localparam int unsigned CTL_SER_EN_LSB = 2;
  localparam int unsigned CTL_FDC_EN_BIT = 4;
  localparam logic [1:0]  LPT_MODE_WIDE  = 2'd2;
  localparam logic [1:0]  LPT_MODE_OFF   = 2'd3;

  // routing offsets
  localparam logic [7:0] RT_OFF_DMA     = 8'h50;
  localparam logic [7:0] RT_OFF_FL_IRQ  = 8'h51;
  localparam logic [7:0] RT_OFF_SER_IRQ = 8'h52;

  // window sizes in address bits
  localparam int unsigned SPAN_NARROW_LOG2 = 2;
  localparam int unsigned SPAN_WIDE_LOG2   = 3;

  typedef struct packed {
    logic [DMA_W-1:0] fdc_dma;
    logic [DMA_W-1:0] lpt_dma;
    logic [IRQ_W-1:0] fdc_irq;
    logic [IRQ_W-1:0] lpt_irq;
    logic [IRQ_W-1:0] sera_irq;
    logic [IRQ_W-1:0] serb_irq;
  } route_t;

  localparam route_t ROUTE_RST = '{
    fdc_dma:  2'd2,
    lpt_dma:  2'd3,
    fdc_irq:  4'd0,
    lpt_irq:  4'd0,
    sera_irq: 4'd0,
    serb_irq: 4'd0
  };

endpackage

// File: rtl/lpr_route_regs.sv
module lpr_route_regs
  import lpr_pkg::*;
#(
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  output route_t            route_q
);

  localparam int unsigned HI_LSB = DATA_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= ROUTE_RST;
    end else if (wr_fire) begin
      case (wr_off)
        OFF_W'(RT_OFF_DMA): begin
          route_q.fdc_dma <= wr_data[DMA_W-1:0];
          route_q.lpt_dma <= wr_data[2*DMA_W-1:DMA_W];
        end
        OFF_W'(RT_OFF_FL_IRQ): begin
          route_q.fdc_irq <= wr_data[IRQ_W-1:0];
          route_q.lpt_irq <= wr_data[HI_LSB+IRQ_W-1:HI_LSB];
        end
        OFF_W'(RT_OFF_SER_IRQ): begin
          route_q.sera_irq <= wr_data[IRQ_W-1:0];
          route_q.serb_irq <= wr_data[HI_LSB+IRQ_W-1:HI_LSB];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lpr_resmap.sv
module lpr_resmap
  import lpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [CFG_W-1:0]  cfg_ctl,
  input  logic [CFG_W-1:0]  cfg_fdc,
  input  logic [CFG_W-1:0]  cfg_lpt,
  input  logic [CFG_W-1:0]  cfg_ser_a,
  input  logic [CFG_W-1:0]  cfg_ser_b,
  output logic [ADDR_W-1:0] base [NUM_DEV],
  output logic [ADDR_W-1:0] mask [NUM_DEV],
  output logic [NUM_DEV-1:0] en,
  output logic              lpt_wide
);

  localparam int unsigned PAD_W = ADDR_W - CFG_W - 2;
  localparam logic [ADDR_W-1:0] LPT_MIN     = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] LPT_MAX_NAR = ADDR_W'('h3FC);
  localparam logic [ADDR_W-1:0] LPT_MAX_WID = ADDR_W'('h3F8);
  localparam logic [ADDR_W-1:0] MASK_NAR    = ~ADDR_W'((1 << SPAN_NARROW_LOG2) - 1);
  localparam logic [ADDR_W-1:0] MASK_WID    = ~ADDR_W'((1 << SPAN_WIDE_LOG2) - 1);
  localparam logic [CFG_W-1:0]  FDC_KEEP    = CFG_W'('hFC);
  localparam logic [CFG_W-1:0]  SER_KEEP    = CFG_W'('hFE);

  // floppy
  assign base[DEV_FDC] = {{PAD_W{1'b0}}, cfg_fdc & FDC_KEEP, 2'b00};
  assign mask[DEV_FDC] = MASK_WID;
  assign en[DEV_FDC]   = cfg_ctl[CTL_FDC_EN_BIT];

  // serial ports
  logic [CFG_W-1:0] ser_cfg [NUM_SER];
  assign ser_cfg[0] = cfg_ser_a;
  assign ser_cfg[1] = cfg_ser_b;

  for (genvar s = 0; s < NUM_SER; s++) begin : g_ser
    localparam int unsigned IDX = int'(DEV_SERA) + s;
    assign base[IDX] = {{PAD_W{1'b0}}, ser_cfg[s] & SER_KEEP, 2'b00};
    assign mask[IDX] = MASK_WID;
    assign en[IDX]   = cfg_ctl[CTL_SER_EN_LSB + s];
  end

  // parallel port
  logic [1:0]        lpt_mode;
  logic [ADDR_W-1:0] lpt_raw;
  logic [ADDR_W-1:0] lpt_aligned;
  logic [ADDR_W-1:0] lpt_limit;
  logic              lpt_in_range;

  assign lpt_mode = cfg_ctl[1:0];
  assign lpt_wide = (lpt_mode == LPT_MODE_WIDE);
  assign lpt_raw  = {{PAD_W{1'b0}}, cfg_lpt, 2'b00};

  always_comb begin
    if (lpt_wide) begin
      lpt_aligned = lpt_raw & MASK_WID;
      lpt_limit   = LPT_MAX_WID;
    end else begin
      lpt_aligned = lpt_raw & MASK_NAR;
      lpt_limit   = LPT_MAX_NAR;
    end
  end

  assign lpt_in_range  = (lpt_aligned >= LPT_MIN) && (lpt_aligned <= lpt_limit);
  assign base[DEV_LPT] = lpt_aligned;
  assign mask[DEV_LPT] = lpt_wide ? MASK_WID : MASK_NAR;
  assign en[DEV_LPT]   = (lpt_mode != LPT_MODE_OFF) && lpt_in_range;

endmodule

// File: rtl/lpr_window_cmp.sv
module lpr_window_cmp #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              en,
  output logic              hit
);

  logic [ADDR_W-1:0] diff;

  assign diff = (addr ^ base) & mask;
  assign hit  = en && (diff == '0);

endmodule

// File: rtl/lpr_prio_sel.sv
module lpr_prio_sel #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] hit,
  output logic [N-1:0] sel
);

  assign sel[0] = hit[0];

  for (genvar i = 1; i < N; i++) begin : g_prio
    assign sel[i] = hit[i] && !(|hit[i-1:0]);
  end

endmodule

// File: rtl/lpr_decoder.sv
module lpr_decoder
  import lpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_ctl,
  input  logic [7:0]        cfg_fdc,
  input  logic [7:0]        cfg_lpt,
  input  logic [7:0]        cfg_ser_a,
  input  logic [7:0]        cfg_ser_b,
  input  logic              route_valid,
  output logic              route_ready,
  input  logic [7:0]        route_off,
  input  logic [7:0]        route_data,
  input  logic [ADDR_W-1:0] io_addr,
  output logic [ADDR_W-1:0] fdc_base,
  output logic              fdc_en,
  output logic [3:0]        fdc_irq,
  output logic [1:0]        fdc_dma,
  output logic [ADDR_W-1:0] sera_base,
  output logic              sera_en,
  output logic [3:0]        sera_irq,
  output logic [ADDR_W-1:0] serb_base,
  output logic              serb_en,
  output logic [3:0]        serb_irq,
  output logic [ADDR_W-1:0] lpt_base,
  output logic              lpt_en,
  output logic              lpt_wide,
  output logic [3:0]        lpt_irq,
  output logic [1:0]        lpt_dma,
  output logic [3:0]        sel
);

  route_t            route_q;
  logic              wr_fire;
  logic [ADDR_W-1:0] base [NUM_DEV];
  logic [ADDR_W-1:0] mask [NUM_DEV];
  logic [NUM_DEV-1:0] en;
  logic [NUM_DEV-1:0] hit;

  // no back-pressure on the routing channel
  assign route_ready = 1'b1;
  assign wr_fire     = route_valid && route_ready;

  lpr_route_regs #(
    .OFF_W  (8),
    .DATA_W (8)
  ) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_off  (route_off),
    .wr_data (route_data),
    .route_q (route_q)
  );

  lpr_resmap #(
    .ADDR_W (ADDR_W)
  ) u_map (
    .cfg_ctl   (cfg_ctl),
    .cfg_fdc   (cfg_fdc),
    .cfg_lpt   (cfg_lpt),
    .cfg_ser_a (cfg_ser_a),
    .cfg_ser_b (cfg_ser_b),
    .base      (base),
    .mask      (mask),
    .en        (en),
    .lpt_wide  (lpt_wide)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_win
    lpr_window_cmp #(
      .ADDR_W (ADDR_W)
    ) u_cmp (
      .addr (io_addr),
      .base (base[d]),
      .mask (mask[d]),
      .en   (en[d]),
      .hit  (hit[d])
    );
  end

  lpr_prio_sel #(
    .N (SEL_W)
  ) u_prio (
    .hit (hit),
    .sel (sel)
  );

  assign fdc_base  = base[DEV_FDC];
  assign sera_base = base[DEV_SERA];
  assign serb_base = base[DEV_SERB];
  assign lpt_base  = base[DEV_LPT];

  assign fdc_en  = en[DEV_FDC];
  assign sera_en = en[DEV_SERA];
  assign serb_en = en[DEV_SERB];
  assign lpt_en  = en[DEV_LPT];

  // resources of a disabled device read zero
  assign fdc_irq  = fdc_en  ? route_q.fdc_irq  : '0;
  assign fdc_dma  = fdc_en  ? route_q.fdc_dma  : '0;
  assign sera_irq = sera_en ? route_q.sera_irq : '0;
  assign serb_irq = serb_en ? route_q.serb_irq : '0;
  assign lpt_irq  = lpt_en  ? route_q.lpt_irq  : '0;
  assign lpt_dma  = lpt_en  ? route_q.lpt_dma  : '0;

endmodule

// File: rtl/lpr_decoder_chk.sv
module lpr_decoder_chk
  import lpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_ctl,
  input logic              route_valid,
  input logic [7:0]        route_off,
  input logic [7:0]        route_data,
  input route_t            route_q,
  input logic [ADDR_W-1:0] io_addr,
  input logic [ADDR_W-1:0] fdc_base,
  input logic              fdc_en,
  input logic [3:0]        fdc_irq,
  input logic [1:0]        fdc_dma,
  input logic [ADDR_W-1:0] sera_base,
  input logic [ADDR_W-1:0] serb_base,
  input logic [ADDR_W-1:0] lpt_base,
  input logic              lpt_en,
  input logic              lpt_wide,
  input logic [3:0]        lpt_irq,
  input logic [1:0]        lpt_dma,
  input logic [3:0]        sel
);

  logic other_off;
  assign other_off = (route_off != RT_OFF_DMA) && (route_off != RT_OFF_FL_IRQ) &&
                     (route_off != RT_OFF_SER_IRQ);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R10

  AST_SEL_FDC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel[0] |-> (fdc_en && io_addr[ADDR_W-1:3] == fdc_base[ADDR_W-1:3])); // R10

  AST_LPT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lpt_en |-> (cfg_ctl[1:0] != 2'd3 && lpt_base >= ADDR_W'('h100) &&
                lpt_base <= (lpt_wide ? ADDR_W'('h3F8) : ADDR_W'('h3FC)))); // R4

  AST_LPT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    lpt_wide |-> lpt_base[2:0] == 3'd0); // R3

  AST_SER_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    sera_base[2:0] == 3'd0 && serb_base[2:0] == 3'd0); // R2

  AST_FDC_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_en |-> (fdc_irq == 4'd0 && fdc_dma == 2'd0)); // R11

  AST_LPT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lpt_en |-> (lpt_irq == 4'd0 && lpt_dma == 2'd0)); // R11

  AST_ROUTE_DMA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && route_off == RT_OFF_DMA) |=>
      (route_q.fdc_dma == $past(route_data[1:0]) &&
       route_q.lpt_dma == $past(route_data[3:2]))); // R5

  AST_ROUTE_IRQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && route_off == RT_OFF_SER_IRQ) |=>
      (route_q.sera_irq == $past(route_data[3:0]) &&
       route_q.serb_irq == $past(route_data[7:4]))); // R7

  AST_ROUTE_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && other_off) |=> $stable(route_q)); // R9

endmodule

bind lpr_decoder lpr_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_ctl     (cfg_ctl),
  .route_valid (route_valid),
  .route_off   (route_off),
  .route_data  (route_data),
  .route_q     (route_q),
  .io_addr     (io_addr),
  .fdc_base    (fdc_base),
  .fdc_en      (fdc_en),
  .fdc_irq     (fdc_irq),
  .fdc_dma     (fdc_dma),
  .sera_base   (sera_base),
  .serb_base   (serb_base),
  .lpt_base    (lpt_base),
  .lpt_en      (lpt_en),
  .lpt_wide    (lpt_wide),
  .lpt_irq     (lpt_irq),
  .lpt_dma     (lpt_dma),
  .sel         (sel)
);

// File: tb/lpr_decoder_test.sv
module lpr_decoder_test;

  localparam time CLK_P    = 10;
  localparam int  WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_ctl = 8'h1C, cfg_fdc = 8'hFC, cfg_lpt = 8'hDE;
  logic [7:0]  cfg_ser_a = 8'hFE, cfg_ser_b = 8'hBE;
  logic        route_valid = 1'b0;
  logic        route_ready;
  logic [7:0]  route_off = 8'h00, route_data = 8'h00;
  logic [15:0] io_addr = 16'h0000;
  logic [15:0] fdc_base, sera_base, serb_base, lpt_base;
  logic        fdc_en, sera_en, serb_en, lpt_en, lpt_wide;
  logic [3:0]  fdc_irq, sera_irq, serb_irq, lpt_irq, sel;
  logic [1:0]  fdc_dma, lpt_dma;

  lpr_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_ctl(cfg_ctl), .cfg_fdc(cfg_fdc),
    .cfg_lpt(cfg_lpt), .cfg_ser_a(cfg_ser_a), .cfg_ser_b(cfg_ser_b),
    .route_valid(route_valid), .route_ready(route_ready),
    .route_off(route_off), .route_data(route_data), .io_addr(io_addr),
    .fdc_base(fdc_base), .fdc_en(fdc_en), .fdc_irq(fdc_irq), .fdc_dma(fdc_dma),
    .sera_base(sera_base), .sera_en(sera_en), .sera_irq(sera_irq),
    .serb_base(serb_base), .serb_en(serb_en), .serb_irq(serb_irq),
    .lpt_base(lpt_base), .lpt_en(lpt_en), .lpt_wide(lpt_wide),
    .lpt_irq(lpt_irq), .lpt_dma(lpt_dma), .sel(sel)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // expected routing state, kept from the writes the bench makes
  logic [1:0] e_fdc_dma = 2'd2, e_lpt_dma = 2'd3;
  logic [3:0] e_fdc_irq = 4'd0, e_lpt_irq = 4'd0, e_sera_irq = 4'd0, e_serb_irq = 4'd0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string rt_req);
    logic [15:0] ef, ea, eb, el;
    logic        fen, aen, ben, len, wide, hf, ha, hb, hl;
    logic [3:0]  es;
    ef   = {6'b0, cfg_fdc & 8'hFC, 2'b00};
    ea   = {6'b0, cfg_ser_a & 8'hFE, 2'b00};
    eb   = {6'b0, cfg_ser_b & 8'hFE, 2'b00};
    fen  = cfg_ctl[4];
    aen  = cfg_ctl[2];
    ben  = cfg_ctl[3];
    wide = (cfg_ctl[1:0] == 2'd2);
    el   = {6'b0, cfg_lpt, 2'b00} & (wide ? 16'h0FF8 : 16'h0FFC);
    len  = (cfg_ctl[1:0] != 2'd3) && (el >= 16'h0100) &&
           (el <= (wide ? 16'h03F8 : 16'h03FC));
    hf = fen && (io_addr[15:3] == ef[15:3]);
    ha = aen && (io_addr[15:3] == ea[15:3]);
    hb = ben && (io_addr[15:3] == eb[15:3]);
    hl = len && (wide ? (io_addr[15:3] == el[15:3]) : (io_addr[15:2] == el[15:2]));
    es = hf ? 4'b0001 : ha ? 4'b0010 : hb ? 4'b0100 : hl ? 4'b1000 : 4'b0000;
    chk("R1", "fdc_base/en", {fdc_base, 15'd0, fdc_en}, {ef, 15'd0, fen});
    chk("R2", "sera_base/en", {sera_base, 15'd0, sera_en}, {ea, 15'd0, aen});
    chk("R2", "serb_base/en", {serb_base, 15'd0, serb_en}, {eb, 15'd0, ben});
    chk("R3", "lpt_base/wide", {lpt_base, 15'd0, lpt_wide}, {el, 15'd0, wide});
    chk("R4", "lpt_en", 32'(lpt_en), 32'(len));
    chk("R10", "sel", 32'(sel), 32'(es));
    chk(rt_req, "irq/dma (R11 gating)",
        {fdc_irq, sera_irq, serb_irq, lpt_irq, 4'd0, fdc_dma, lpt_dma, 4'd0},
        {fen ? e_fdc_irq : 4'd0, aen ? e_sera_irq : 4'd0, ben ? e_serb_irq : 4'd0,
         len ? e_lpt_irq : 4'd0, 4'd0, fen ? e_fdc_dma : 2'd0,
         len ? e_lpt_dma : 2'd0, 4'd0});
  endtask

  task automatic route_wr(input logic [7:0] off, input logic [7:0] d, input string req);
    @(negedge clk);
    route_valid = 1'b1;
    route_off   = off;
    route_data  = d;
    #1;
    chk("R12", "route_ready", 32'(route_ready), 32'd1);
    @(negedge clk);
    route_valid = 1'b0;
    case (off)
      8'h50: begin e_fdc_dma = d[1:0]; e_lpt_dma = d[3:2]; end
      8'h51: begin e_fdc_irq = d[3:0]; e_lpt_irq = d[7:4]; end
      8'h52: begin e_sera_irq = d[3:0]; e_serb_irq = d[7:4]; end
      default: ;
    endcase
    #1;
    check_state(req);
  endtask

  initial begin
    // R8: reset values with all four devices enabled
    io_addr = 16'h03F0;
    repeat (3) @(negedge clk);
    #1;
    check_state("R8");
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_state("R8");

    // R5 R6 R7 routing loads, R11 gating on the loaded values
    route_wr(8'h50, 8'h06, "R5");
    route_wr(8'h50, 8'h0D, "R5");
    route_wr(8'h51, 8'h7A, "R6");
    route_wr(8'h52, 8'h43, "R7");
    route_wr(8'h52, 8'hC5, "R7");
    // R9: other offsets leave routing untouched
    route_wr(8'h4F, 8'hFF, "R9");
    route_wr(8'h53, 8'h00, "R9");
    route_wr(8'hD0, 8'h99, "R9");
    route_wr(8'h00, 8'h11, "R9");
    // R11: each enable off in turn
    for (int k = 0; k < 32; k++) begin
      cfg_ctl = 8'(k);
      #1;
      check_state("R11");
    end

    // R1: floppy base sweep, enable on and off
    cfg_ctl = 8'h03;
    for (int c = 0; c < 256; c++) begin
      for (int e = 0; e < 2; e++) begin
        logic [15:0] b;
        cfg_fdc    = 8'(c);
        cfg_ctl[4] = e[0];
        b = {6'b0, cfg_fdc & 8'hFC, 2'b00};
        io_addr = b;          #1; check_state("R11");
        io_addr = b + 16'd7;  #1; check_state("R11");
        io_addr = b + 16'd8;  #1; check_state("R11");
        io_addr = b - 16'd1;  #1; check_state("R11");
      end
    end

    // R2: serial base sweeps, both ports enabled, floppy off
    cfg_ctl = 8'h0F;
    for (int c = 0; c < 256; c++) begin
      logic [15:0] b;
      cfg_ser_a = 8'(c);
      cfg_ser_b = 8'(255 - c);
      b = {6'b0, cfg_ser_a & 8'hFE, 2'b00};
      io_addr = b;          #1; check_state("R11");
      io_addr = b + 16'd7;  #1; check_state("R11");
      io_addr = b + 16'd8;  #1; check_state("R11");
      b = {6'b0, cfg_ser_b & 8'hFE, 2'b00};
      io_addr = b + 16'd3;  #1; check_state("R11");
    end

    // R3 R4: parallel sweep over every mode and base byte
    cfg_ser_a = 8'h00;
    cfg_ser_b = 8'h00;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 256; c++) begin
        logic [15:0] b;
        cfg_ctl = 8'(m);
        cfg_lpt = 8'(c);
        b = {6'b0, cfg_lpt, 2'b00};
        io_addr = b;          #1; check_state("R11");
        io_addr = b + 16'd3;  #1; check_state("R11");
        io_addr = b + 16'd4;  #1; check_state("R11");
        io_addr = b + 16'd7;  #1; check_state("R11");
        io_addr = b - 16'd4;  #1; check_state("R11");
      end
    end

    // R10: overlapping windows near 0x3F0, every enable combination
    cfg_fdc   = 8'hFC;
    cfg_ser_a = 8'hFC;
    cfg_ser_b = 8'hFF;
    cfg_lpt   = 8'hFD;
    for (int k = 0; k < 32; k++) begin
      for (int a = 16'h03E8; a < 16'h0404; a++) begin
        cfg_ctl = 8'(k);
        io_addr = 16'(a);
        #1;
        check_state("R11");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule